// File: doc/BRIEF.md
# Bus-Polled LED Walker

A small memory-mapped peripheral with a pipelined Wishbone subordinate port and a row of LED outputs. When a bus write is accepted while the block is idle, a walk begins. A single lit LED steps from the lowest output up to the highest and then back down to the lowest. The walk advances one position per clock. At the end the block returns to idle with every LED dark.

Software keeps track of the walk by reading the peripheral. A read returns the walker's current state number. That number is 0 when idle, counts 1 through 2·LEDS−1 during a walk, and then falls back to 0. A manager can therefore poll with reads until it sees 0. Reads are never held off. A write that arrives during a walk is stalled until the walk is over, and is then accepted and starts a new walk. The address bit and the write data carry no meaning: every request acts on the one walker.

Top module: `led_walk_periph`

## Requirements
- R1: A synchronous active-high reset sets the state to 0, turns every LED off and drives acknowledge low.
- R2: A write accepted in idle (cycle, strobe and write enable high, stall low) makes the state 1 on the next clock edge, whatever the write data is. A request with cycle low starts nothing.
- R3: While the state is non-zero it rises by exactly one per clock, up to 2·LEDS−1 (11 for six LEDs). The state after that is 0. In idle the state stays 0 until a write is accepted.
- R4: LED output bit k (k = 0 is the lowest) is lit in state k+1 and in state 2·LEDS−1−k. No other LED is lit. All LEDs are off in state 0.
- R5: Acknowledge goes high for one clock, in the cycle after each accepted request. It is low whenever cycle is low and after any cycle with no accepted request.
- R6: Stall equals (state non-zero AND write enable), as a combinational function of the current inputs. A read is never stalled.
- R7: While acknowledge is high, read data bits [SW−1:0] hold the current state and all higher bits are 0.
- R8: The address bit has no effect. Writes and reads to address 1 behave exactly like those to address 0.
- R9: A write held against stall does not disturb the walk in progress. It is accepted in the first cycle where the state is 0, which is after exactly 2·LEDS−1 stalled cycles when it arrives right after a walk starts, and it then starts a new walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_cyc | input | 1 | Bus cycle active |
| i_stb | input | 1 | Request strobe |
| i_we | input | 1 | Write enable (1 = write) |
| i_addr | input | 1 | Address bit (ignored) |
| i_wdata | input | DW (32) | Write data (ignored) |
| o_ack | output | 1 | Request acknowledge, one clock after acceptance |
| o_stall | output | 1 | Request held off (writes during a walk) |
| o_rdata | output | DW (32) | Read data: zero-extended state number |
| o_led | output | LEDS (6) | LED outputs, one lit during a walk |

## Verification
The bench builds the block with its defaults: six LEDs, a 4-bit state and a 32-bit data path. At that size every state of a walk can be visited many times over. Several walks are swept end to end, with back-to-back reads and with idle gaps. In every cycle the bench compares acknowledge, stall, read data and all six LEDs against a counter model kept inside the bench. The small state range also makes the full stalled-write window (eleven cycles) short enough to count exactly. Data patterns and both address values are varied across the walks.

// File: rtl/led_walk_pkg.sv
package led_walk_pkg;

    // Bus request fields as seen by the port logic
    typedef struct packed {
        logic cyc;
        logic stb;
        logic we;
    } bus_req_t;

    // Outcome of a request in one cycle
    typedef struct packed {
        logic accept;
        logic wr_start;
    } bus_evt_t;

    // Highest state number of a walk over n LEDs
    function automatic int unsigned walk_last(input int unsigned n);
        return 2 * n - 1;
    endfunction

    // Width needed to hold states 0 .. walk_last(n)
    function automatic int unsigned walk_width(input int unsigned n);
        return $clog2(2 * n);
    endfunction

endpackage

// File: rtl/walk_seq.sv
module walk_seq
    import led_walk_pkg::*;
#(
    parameter int unsigned LEDS = 6,
    parameter int unsigned SW   = walk_width(LEDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic [SW-1:0] state,
    output logic          busy
);
    localparam logic [SW-1:0] LAST = SW'(walk_last(LEDS));
    localparam logic [SW-1:0] ONE  = SW'(1);

    logic [SW-1:0] state_q;

    assign busy  = (state_q != '0);
    assign state = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (busy) begin
            state_q <= (state_q == LAST) ? '0 : state_q + ONE;
        end else if (start) begin
            state_q <= ONE;
        end
    end

    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && state_q != LAST) |=> (state_q == $past(state_q) + ONE));
    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == LAST) |=> (state_q == '0));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> (state_q == '0));
endmodule

// File: rtl/walk_led_dec.sv
module walk_led_dec
    import led_walk_pkg::*;
#(
    parameter int unsigned LEDS = 6,
    parameter int unsigned SW   = walk_width(LEDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [SW-1:0]   state,
    output logic [LEDS-1:0] led
);
    localparam int unsigned LAST = walk_last(LEDS);

    for (genvar k = 0; k < LEDS; k++) begin : g_led
        localparam logic [SW-1:0] UP_ST   = SW'(k + 1);
        localparam logic [SW-1:0] DOWN_ST = SW'(LAST - k);
        assign led[k] = (state == UP_ST) || (state == DOWN_ST);
    end

    // R4
    single_led_chk: assert property (@(posedge clk) disable iff (rst)
        (state != '0) |-> ($countones(led) == 1));
    // R4
    dark_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == '0) |-> (led == '0));
endmodule

// File: rtl/walk_wb_port.sv
module walk_wb_port
    import led_walk_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned SW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_req_t      req,
    input  logic          busy,
    input  logic [SW-1:0] state,
    output logic          ack,
    output logic          stall,
    output logic [DW-1:0] rdata,
    output logic          wr_start
);
    bus_evt_t evt;
    logic     ack_q;

    assign stall        = busy & req.we;
    assign evt.accept   = req.cyc & req.stb & ~stall;
    assign evt.wr_start = evt.accept & req.we;
    assign wr_start     = evt.wr_start;

    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= evt.accept;
    end

    assign ack   = ack_q & req.cyc;
    assign rdata = DW'(state);

    // R5
    ack_follows_chk: assert property (@(posedge clk) disable iff (rst)
        evt.accept |=> ack_q);
    // R5
    stalled_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (req.cyc && req.stb && stall) |=> !ack_q);
    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> (rdata >> SW) == '0);
endmodule

// File: rtl/led_walk_periph.sv
module led_walk_periph
    import led_walk_pkg::*;
#(
    parameter int unsigned LEDS = 6,
    parameter int unsigned DW   = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            i_cyc,
    input  logic            i_stb,
    input  logic            i_we,
    input  logic            i_addr,
    input  logic [DW-1:0]   i_wdata,
    output logic            o_ack,
    output logic            o_stall,
    output logic [DW-1:0]   o_rdata,
    output logic [LEDS-1:0] o_led
);
    localparam int unsigned SW = walk_width(LEDS);

    bus_req_t      req;
    logic [SW-1:0] state;
    logic          busy;
    logic          wr_start;
    logic          unused_req_bits;

    assign req             = '{cyc: i_cyc, stb: i_stb, we: i_we};
    assign unused_req_bits = ^{i_addr, i_wdata};

    walk_wb_port #(.DW(DW), .SW(SW)) u_port (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .busy     (busy),
        .state    (state),
        .ack      (o_ack),
        .stall    (o_stall),
        .rdata    (o_rdata),
        .wr_start (wr_start)
    );

    walk_seq #(.LEDS(LEDS), .SW(SW)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (wr_start),
        .state (state),
        .busy  (busy)
    );

    walk_led_dec #(.LEDS(LEDS), .SW(SW)) u_dec (
        .clk   (clk),
        .rst   (rst),
        .state (state),
        .led   (o_led)
    );

    // R2
    start_by_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(i_cyc && i_stb && i_we));
    // R6
    read_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (i_cyc && i_stb && !i_we) |-> !o_stall);
endmodule

// File: tb/test_led_walk_periph.sv
`timescale 1ns/1ps
module test_led_walk_periph;
    localparam int N    = 6;
    localparam int DW   = 32;
    localparam int LAST = 2 * N - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          i_cyc = 1'b0, i_stb = 1'b0, i_we = 1'b0, i_addr = 1'b0;
    logic [DW-1:0] i_wdata = '0;
    logic          o_ack, o_stall;
    logic [DW-1:0] o_rdata;
    logic [N-1:0]  o_led;

    int checks = 0;
    int fails  = 0;
    int model  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    led_walk_periph #(.LEDS(N), .DW(DW)) i_led_walk_periph (
        .clk(clk), .rst(rst), .i_cyc(i_cyc), .i_stb(i_stb), .i_we(i_we),
        .i_addr(i_addr), .i_wdata(i_wdata), .o_ack(o_ack), .o_stall(o_stall),
        .o_rdata(o_rdata), .o_led(o_led)
    );

    function automatic logic [N-1:0] exp_led(input int s);
        if (s == 0) return '0;
        if (s <= N) return N'(1) << (s - 1);
        return N'(1) << (LAST - s);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // One bus cycle: drive at negedge, check stall, then check registered results after the edge
    task automatic step(input logic c, input logic s, input logic w, input logic a,
                        input logic [DW-1:0] d, output bit stalled);
        bit exp_stall, acc;
        @(negedge clk);
        i_cyc = c; i_stb = s; i_we = w; i_addr = a; i_wdata = d;
        #1;
        exp_stall = (model != 0) && w;
        stalled = o_stall;
        chk(o_stall == exp_stall, "R6 stall", o_stall, exp_stall);
        acc = c && s && !exp_stall;
        @(posedge clk);
        #1;
        if (model != 0) model = (model == LAST) ? 0 : model + 1;
        else if (acc && w) model = 1;
        chk(o_ack == (acc && c), "R5 ack", o_ack, acc && c);
        if (o_ack) chk(o_rdata == DW'(model), "R7 R3 read data", o_rdata, model);
        chk(o_led == exp_led(model), "R4 led", o_led, exp_led(model));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        finish_run();
    end

    initial begin
        bit st;
        int stall_cnt;
        logic [DW-1:0] pats [4] = '{32'h0, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h0000_0001};
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(o_ack == 1'b0, "R1 ack", o_ack, 0);
        chk(o_led == '0, "R1 led", o_led, 0);
        chk(o_rdata == '0, "R1 state", o_rdata, 0);
        @(negedge clk); rst = 1'b0;

        step(1, 1, 0, 0, '0, st);
        chk(o_ack && o_rdata == 0, "R1 idle read", o_rdata, 0);

        // Walk sweeps with varied data and address
        for (int p = 0; p < 4; p++) begin
            step(1, 1, 1, p[0], pats[p], st);
            chk(o_ack && o_rdata == 1, "R2 start state", o_rdata, 1);
            for (int k = 0; k < LAST; k++) begin
                if (p == 2) step(0, 0, 0, 0, '0, st);
                step(1, 1, 0, ~p[0], '0, st);
            end
            chk(model == 0, "R3 walk complete", model, 0);
            step(1, 1, 0, p[0], '0, st);
            chk(o_ack && o_rdata == 0, "R3 back to zero", o_rdata, 0);
        end

        // R8: address 1 acts the same as address 0
        step(1, 1, 1, 1, 32'h1234_5678, st);
        chk(o_rdata == 1 && o_led == 6'b000001, "R8 addr1 write", o_rdata, 1);
        step(1, 1, 0, 1, '0, st);
        chk(o_ack && o_rdata == 2, "R8 addr1 read", o_rdata, 2);
        for (int k = 0; k < LAST; k++) step(1, 1, 0, 0, '0, st);

        // Cycle low with strobe: no start, no ack
        step(0, 1, 1, 0, 32'hDEAD_BEEF, st);
        chk(o_ack == 0, "R5 cyc low ack", o_ack, 0);
        step(1, 1, 0, 0, '0, st);
        chk(o_rdata == 0, "R2 cyc low no start", o_rdata, 0);

        // R9: write held against stall
        step(1, 1, 1, 0, 32'h5, st);
        stall_cnt = 0;
        st = 1;
        while (st && stall_cnt < 3 * LAST) begin
            step(1, 1, 1, 0, 32'h5, st);
            if (st) stall_cnt++;
        end
        chk(stall_cnt == LAST, "R9 stalled cycles", stall_cnt, LAST);
        chk(o_ack && o_rdata == 1, "R9 restart after stall", o_rdata, 1);
        for (int k = 0; k < LAST + 2; k++) step(1, 1, 0, 0, '0, st);
        chk(model == 0 && o_led == '0, "R3 final idle", o_led, 0);

        step(0, 0, 0, 0, '0, st);
        finish_run();
    end
endmodule